// File: doc/BRIEF.md
# Polled Thermal Supervision Filter

This block turns raw comparator decisions about battery temperature and die temperature into stable status. A periodic poll strobe (nominally every 128 ms) marks the only cycles in which the comparator inputs are looked at. A state bit changes only after a run of consecutive polled samples, three by default, all call for the new value. A sample that agrees with the present state resets the run.

The battery channel drives a charge-enable. The sense voltage falls as the cell heats. Charging is blocked when the sense voltage drops below the lowered threshold (reference minus hysteresis). It is released only once the sense voltage climbs back above the reference itself, so the two thresholds form a hysteresis band. This channel is watched only while a fast or trickle charge mode is on.

The die channel is watched only in active mode. When it confirms an over-temperature, it sets a status bit and raises an interrupt that holds until acknowledged. Leaving a channel's mode discards its partial run, so older samples never count toward a later decision.

Top module: `thsup_top`

## Requirements
- R1: After synchronous reset, `charge_en` is 1, `status` is 2'b00 and `irq` is 0.
- R2: Comparator inputs are sampled only in cycles where `poll_tick` is 1. In other cycles no output changes, except `irq` through R9.
- R3: A state bit flips only at the third consecutive polled sample calling for the opposite value. The bit changes in the cycle after that sample. A polled sample matching the current state restarts the count.
- R4: While charging is enabled, a polled sample with `bat_gt_low`=0 (sense below reference minus hysteresis) calls for blocking. A sample with `bat_gt_low`=1 does not call for blocking.
- R5: While charging is blocked, only a polled sample with `bat_gt_ref`=1 (sense above reference) calls for re-enabling. A sense level between the two thresholds keeps charging blocked.
- R6: The battery channel acts only while `mode_fast_chg` or `mode_trickle_chg` is 1. Outside these modes its samples are ignored, `charge_en` holds its value, and its partial count clears.
- R7: The die channel acts only while `mode_active` is 1. Outside active mode its samples are ignored, its flag holds, and its partial count clears.
- R8: `status[0]` is 1 while charging is blocked, the inverse of `charge_en`. `status[1]` is the filtered die over-temperature flag (`die_over`=1 means hot). The flag clears again after three consecutive cool samples.
- R9: `irq` goes to 1 in the cycle after `status[1]` rises and stays 1 until a cycle with `irq_ack`=1. A new rise wins over a simultaneous acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| poll_tick | input | 1 | One-cycle poll strobe |
| mode_fast_chg | input | 1 | Fast-charge mode active |
| mode_trickle_chg | input | 1 | Trickle-charge mode active |
| mode_active | input | 1 | Chip active mode |
| bat_gt_ref | input | 1 | Battery sense above reference |
| bat_gt_low | input | 1 | Battery sense above reference minus hysteresis |
| die_over | input | 1 | Die temperature above limit |
| irq_ack | input | 1 | Interrupt acknowledge |
| charge_en | output | 1 | Charging permitted |
| status | output | 2 | {die over-temperature, charge blocked} |
| irq | output | 1 | Over-temperature interrupt |

## Verification
The bench builds the block with the default vote depth of 3. With this depth every count value, from zero through the flipping sample, can be reached within a few polls. Each input reduces to a tiny alphabet: three battery sense levels, a hot/cool die bit, three mode enables, the strobe and the acknowledge. A long pseudo-random walk with sticky inputs therefore visits every combination of state, partial count and mode change many times. Directed sequences pin down interrupted runs, the hysteresis band, history clearing on mode exit, and acknowledge against a coincident set.

// File: rtl/thsup_pkg.sv
package thsup_pkg;

    typedef struct packed {
        logic die_hot;
        logic bat_block;
    } thsup_status_t;

    localparam int unsigned STATUS_W = $bits(thsup_status_t);

    // A polled battery sample calls for "blocked" depending on the present state
    function automatic logic bat_wants_block(input logic blocked,
                                             input logic gt_ref,
                                             input logic gt_low);
        return blocked ? !gt_ref : !gt_low;
    endfunction

endpackage

// File: rtl/thsup_vote_filter.sv
module thsup_vote_filter #(
    parameter int unsigned DEPTH = 3,
    parameter bit          INIT  = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic tick,
    input  logic sample,
    output logic state
);
    localparam int unsigned CW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic state_q, state_d;
    logic differs;

    assign differs = (sample != state_q);
    assign state   = state_q;

    generate
        if (DEPTH <= 1) begin : g_direct
            always_comb begin
                state_d = state_q;
                if (enable && tick && differs)
                    state_d = sample;
            end
        end else begin : g_count
            logic [CW-1:0] run_q, run_d;
            always_comb begin
                state_d = state_q;
                run_d   = run_q;
                if (!enable) begin
                    run_d = '0;
                end else if (tick) begin
                    if (!differs) begin
                        run_d = '0;
                    end else if (run_q == CW'(DEPTH - 1)) begin
                        state_d = sample;
                        run_d   = '0;
                    end else begin
                        run_d = run_q + 1'b1;
                    end
                end
            end
            always_ff @(posedge clk) begin
                if (rst) run_q <= '0;
                else     run_q <= run_d;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) state_q <= INIT;
        else     state_q <= state_d;
    end
endmodule

// File: rtl/thsup_bat_chan.sv
module thsup_bat_chan
    import thsup_pkg::*;
#(
    parameter int unsigned DEPTH = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic tick,
    input  logic gt_ref,
    input  logic gt_low,
    output logic blocked
);
    logic vote;

    assign vote = bat_wants_block(blocked, gt_ref, gt_low);

    thsup_vote_filter #(.DEPTH(DEPTH), .INIT(1'b0)) u_filt (
        .clk    (clk),
        .rst    (rst),
        .enable (enable),
        .tick   (tick),
        .sample (vote),
        .state  (blocked)
    );
endmodule

// File: rtl/thsup_irq_latch.sv
module thsup_irq_latch (
    input  logic clk,
    input  logic rst,
    input  logic flag,
    input  logic ack,
    output logic irq
);
    logic flag_prev_q;
    logic irq_q;
    logic set_evt;

    assign set_evt = flag && !flag_prev_q;
    assign irq     = irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_prev_q <= 1'b0;
            irq_q       <= 1'b0;
        end else begin
            flag_prev_q <= flag;
            if (set_evt)  irq_q <= 1'b1;
            else if (ack) irq_q <= 1'b0;
        end
    end
endmodule

// File: rtl/thsup_top.sv
module thsup_top
    import thsup_pkg::*;
#(
    parameter int unsigned VOTE_DEPTH = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                poll_tick,
    input  logic                mode_fast_chg,
    input  logic                mode_trickle_chg,
    input  logic                mode_active,
    input  logic                bat_gt_ref,
    input  logic                bat_gt_low,
    input  logic                die_over,
    input  logic                irq_ack,
    output logic                charge_en,
    output logic [STATUS_W-1:0] status,
    output logic                irq
);
    thsup_status_t st;
    logic          bat_on;

    assign bat_on = mode_fast_chg || mode_trickle_chg;

    thsup_bat_chan #(.DEPTH(VOTE_DEPTH)) u_bat (
        .clk     (clk),
        .rst     (rst),
        .enable  (bat_on),
        .tick    (poll_tick),
        .gt_ref  (bat_gt_ref),
        .gt_low  (bat_gt_low),
        .blocked (st.bat_block)
    );

    thsup_vote_filter #(.DEPTH(VOTE_DEPTH), .INIT(1'b0)) u_die (
        .clk    (clk),
        .rst    (rst),
        .enable (mode_active),
        .tick   (poll_tick),
        .sample (die_over),
        .state  (st.die_hot)
    );

    thsup_irq_latch u_irq (
        .clk  (clk),
        .rst  (rst),
        .flag (st.die_hot),
        .ack  (irq_ack),
        .irq  (irq)
    );

    assign status    = st;
    assign charge_en = !st.bat_block;
endmodule

// File: rtl/thsup_chk.sv
module thsup_chk (
    input logic       clk,
    input logic       rst,
    input logic       poll_tick,
    input logic       mode_fast_chg,
    input logic       mode_trickle_chg,
    input logic       mode_active,
    input logic       bat_gt_ref,
    input logic       bat_gt_low,
    input logic       irq_ack,
    input logic       charge_en,
    input logic [1:0] status,
    input logic       irq
);
    assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (rst)
        !poll_tick |=> ($stable(charge_en) && $stable(status)));

    assert_block_needs_low_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(charge_en) |-> $past(poll_tick && !bat_gt_low));

    assert_release_needs_ref_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(charge_en) |-> $past(poll_tick && bat_gt_ref));

    assert_bat_idle_R6: assert property (@(posedge clk) disable iff (rst)
        !(mode_fast_chg || mode_trickle_chg) |=> $stable(charge_en));

    assert_die_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !mode_active |=> $stable(status[1]));

    assert_status_mirror_R8: assert property (@(posedge clk) disable iff (rst)
        status[0] != charge_en);

    assert_irq_follows_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(status[1]) |=> irq);

    assert_irq_clear_ack_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(irq) |-> $past(irq_ack));
endmodule

bind thsup_top thsup_chk u_chk (
    .clk              (clk),
    .rst              (rst),
    .poll_tick        (poll_tick),
    .mode_fast_chg    (mode_fast_chg),
    .mode_trickle_chg (mode_trickle_chg),
    .mode_active      (mode_active),
    .bat_gt_ref       (bat_gt_ref),
    .bat_gt_low       (bat_gt_low),
    .irq_ack          (irq_ack),
    .charge_en        (charge_en),
    .status           (status),
    .irq              (irq)
);

// File: tb/tb_thsup_top.sv
module tb_thsup_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst, poll_tick, mode_fast_chg, mode_trickle_chg, mode_active;
    logic bat_gt_ref, bat_gt_low, die_over, irq_ack;
    logic charge_en, irq;
    logic [1:0] status;

    int vectors = 0;
    int errors  = 0;

    // reference model state
    bit m_blk, m_hot, m_hprev, m_irq;
    int m_bcnt, m_dcnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    thsup_top #(.VOTE_DEPTH(3)) dut (
        .clk(clk), .rst(rst), .poll_tick(poll_tick),
        .mode_fast_chg(mode_fast_chg), .mode_trickle_chg(mode_trickle_chg),
        .mode_active(mode_active), .bat_gt_ref(bat_gt_ref),
        .bat_gt_low(bat_gt_low), .die_over(die_over), .irq_ack(irq_ack),
        .charge_en(charge_en), .status(status), .irq(irq)
    );

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_model();
        check("R4 R5 R6 charge_en", {3'b0, charge_en}, {3'b0, !m_blk});
        check("R8 status[0]", {3'b0, status[0]}, {3'b0, m_blk});
        check("R7 R8 status[1]", {3'b0, status[1]}, {3'b0, m_hot});
        check("R9 irq", {3'b0, irq}, {3'b0, m_irq});
    endtask

    // lvl: 0 below low threshold, 1 inside band, 2 above reference
    task automatic step(input bit tk, input int lvl, input bit die,
                        input bit fst, input bit trk, input bit act, input bit ack);
        bit want, nirq;
        poll_tick = tk; bat_gt_low = (lvl >= 1); bat_gt_ref = (lvl == 2);
        die_over = die; mode_fast_chg = fst; mode_trickle_chg = trk;
        mode_active = act; irq_ack = ack;
        @(posedge clk);
        nirq = (m_hot && !m_hprev) ? 1'b1 : (ack ? 1'b0 : m_irq);
        m_hprev = m_hot;
        if (!(fst || trk)) m_bcnt = 0;
        else if (tk) begin
            want = m_blk ? (lvl != 2) : (lvl == 0);
            if (want == m_blk) m_bcnt = 0;
            else if (m_bcnt == 2) begin m_blk = want; m_bcnt = 0; end
            else m_bcnt++;
        end
        if (!act) m_dcnt = 0;
        else if (tk) begin
            if (die == m_hot) m_dcnt = 0;
            else if (m_dcnt == 2) begin m_hot = die; m_dcnt = 0; end
            else m_dcnt++;
        end
        m_irq = nirq;
        @(negedge clk);
        compare_model();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        bit [31:0] rs;
        int lvl; bit fst, trk, act, die;
        rst = 1'b1; poll_tick = 0; mode_fast_chg = 0; mode_trickle_chg = 0;
        mode_active = 0; bat_gt_ref = 1; bat_gt_low = 1; die_over = 0; irq_ack = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_blk = 0; m_hot = 0; m_hprev = 0; m_irq = 0; m_bcnt = 0; m_dcnt = 0;
        // R1 reset state
        check("R1", {charge_en, status, irq}, 4'b1000);

        // R2: no strobe, hot samples everywhere: nothing moves
        repeat (10) step(0, 0, 1, 1, 0, 1, 0);
        check("R2", {charge_en, status, irq}, 4'b1000);

        // R3: two cold-low votes, an agreeing vote, two more: still enabled
        step(1, 0, 0, 1, 0, 0, 0); step(1, 0, 0, 1, 0, 0, 0);
        step(1, 1, 0, 1, 0, 0, 0);
        step(1, 0, 0, 1, 0, 0, 0); step(1, 0, 0, 1, 0, 0, 0);
        check("R3", {3'b0, charge_en}, 4'b0001);
        step(1, 0, 0, 1, 0, 0, 0);
        check("R3 R4", {charge_en, status, irq}, 4'b0010);

        // R5: band level does not release
        repeat (4) step(1, 1, 0, 0, 1, 0, 0);
        check("R5 band", {3'b0, charge_en}, 4'b0000);
        step(1, 2, 0, 0, 1, 0, 0); step(1, 2, 0, 0, 1, 0, 0);
        check("R5 two", {3'b0, charge_en}, 4'b0000);
        step(1, 2, 0, 0, 1, 0, 0);
        check("R5 release", {3'b0, charge_en}, 4'b0001);

        // R6: out of mode ignores samples and clears partial run
        step(1, 0, 0, 1, 0, 0, 0); step(1, 0, 0, 1, 0, 0, 0);
        repeat (4) step(1, 0, 0, 0, 0, 0, 0);
        step(1, 0, 0, 1, 0, 0, 0);
        check("R6", {3'b0, charge_en}, 4'b0001);

        // R7 R8 R9: die over-temperature and interrupt
        step(1, 2, 1, 0, 0, 1, 0); step(1, 2, 1, 0, 0, 1, 0);
        step(1, 2, 1, 0, 0, 0, 0);
        step(1, 2, 1, 0, 0, 1, 0);
        check("R7", {status[1], irq, 2'b0}, 4'b0000);
        step(1, 2, 1, 0, 0, 1, 0); step(1, 2, 1, 0, 0, 1, 0);
        check("R8 hot", {status[1], irq, 2'b0}, 4'b1000);
        step(0, 2, 1, 0, 0, 1, 1);
        check("R9 set wins", {status[1], irq, 2'b0}, 4'b1100);
        repeat (3) step(0, 2, 1, 0, 0, 1, 0);
        check("R9 hold", {3'b0, irq}, 4'b0001);
        step(0, 2, 1, 0, 0, 1, 1);
        check("R9 ack", {3'b0, irq}, 4'b0000);
        repeat (3) step(1, 2, 0, 0, 0, 1, 0);
        check("R8 cool", {status[1], irq, 2'b0}, 4'b0000);

        // sweep with sticky pseudo-random inputs
        rs = 32'h1d2c_3b4a; lvl = 2; fst = 1; trk = 0; act = 1; die = 0;
        for (int i = 0; i < 6000; i++) begin
            rs ^= rs << 13; rs ^= rs >> 17; rs ^= rs << 5;
            if (rs[3:2] == 2'b00) lvl = rs[9:8] % 3;
            if (rs[7:4] == 4'h0) fst = ~fst;
            if (rs[15:12] == 4'h1) trk = ~trk;
            if (rs[19:16] == 4'h2) act = ~act;
            if (rs[21:20] == 2'b00) die = ~die;
            step(rs[24], lvl, die, fst, trk, act, rs[27:25] == 3'b000);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule